// File: doc/BRIEF.md
# Debug Event Status and Delayed Interrupt Controller

This block gathers single-cycle debug event pulses from twelve sources into sticky status bits and decides when a debug interrupt is requested. Each event sets its status bit whatever the machine's debug-enable bit says. The interrupt request is held back while debug-enable is low and is raised as soon as debug-enable and internal-debug-mode are both true with any status bit still pending. This is how an event recorded while interrupts were masked is delivered late.

An imprecise flag records that an event was logged while debug-enable was low. The handler uses it to tell whether the saved return address belongs to the instruction that caused the event or to the instruction that re-enabled debug interrupts. When an external debugger mode is selected, only resources owned by software debug can set the flag. Software clears status bits and the flag by writing ones. A separate output tells the handler to use the critical save/restore pair when the debug auxiliary unit is off.

Event indices in status order: 0 instruction address compare, 1 data address compare, 2 trap, 3 branch taken, 4 instruction complete, 5 interrupt taken, 6 return, 7 unconditional, 8 and 9 external events, 10 critical interrupt taken, 11 critical return.

Top module: `dbg_status_ctrl`

## Requirements
- R1: A pulse on `evt_pulse[i]` sets `status[i]` at the next clock edge, whatever the value of `dbg_en`.
- R2: With `wr_en` high, a 1 in `wr_data[i]` (for i below 12) clears `status[i]` at the next edge. A 0 in that position leaves the bit unchanged.
- R3: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R4: `irq` is high only while `dbg_en` and `int_mode_en` are both high and at least one status bit is set. It stays low while `dbg_en` is low, even with bits pending.
- R5: A status bit recorded earlier raises `irq` in the same cycle that `dbg_en` and `int_mode_en` first become both high. No new event is needed.
- R6: An event pulse arriving while `dbg_en` is low sets `imprecise` at the next edge. This applies when `ext_mode_sel` is low, or when `ext_mode_sel` is high and the matching `sw_own` bit is 1.
- R7: `imprecise` is not set by events arriving while `dbg_en` is high. It is also not set by events on resources with `sw_own` 0 while `ext_mode_sel` is high.
- R8: With `wr_en` high, a 1 in `wr_data[12]` clears `imprecise`. If a qualifying event arrives in the same cycle, the flag stays set.
- R9: `use_crit_pair` is 1 exactly when `aux_en` is 0.
- R10: While `rst_n` is low, all status bits, `imprecise` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 12 | One pulse per debug event source |
| dbg_en | input | 1 | Debug interrupt enable from the machine state |
| int_mode_en | input | 1 | Internal debug mode enable |
| ext_mode_sel | input | 1 | External debugger mode select |
| sw_own | input | 12 | Per-resource ownership by software debug |
| aux_en | input | 1 | Debug auxiliary unit enable |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 13 | Write-one-to-clear mask; bit 12 targets the imprecise flag |
| status | output | 12 | Sticky event status bits |
| imprecise | output | 1 | Event recorded while debug interrupts were disabled |
| irq | output | 1 | Debug interrupt request |
| use_crit_pair | output | 1 | Handler uses the critical save/restore pair |

## Verification
An event pulse and a software clear can land on the same status bit, or on the imprecise flag, in the same cycle. The table drives both in one row: an event on bit 1 together with a write that clears bit 1, and a qualifying masked event together with a write to bit 12. The bench then checks that the bit and the flag read back as 1 on the following cycle. The delayed delivery is tested by setting a bit while masked, confirming `irq` stays low, then raising both enables with no new event and expecting `irq` immediately.

// File: rtl/dbgst_pkg.sv
package dbgst_pkg;

  localparam int unsigned EVT_COUNT = 12;

  // status bit index of each event source
  typedef enum logic [3:0] {
    EV_IADDR   = 4'd0,
    EV_DADDR   = 4'd1,
    EV_TRAP    = 4'd2,
    EV_BRANCH  = 4'd3,
    EV_ICMPL   = 4'd4,
    EV_INTTKN  = 4'd5,
    EV_RETURN  = 4'd6,
    EV_UNCOND  = 4'd7,
    EV_EXT0    = 4'd8,
    EV_EXT1    = 4'd9,
    EV_CRITINT = 4'd10,
    EV_CRITRET = 4'd11
  } evt_idx_e;

endpackage

// File: rtl/dbgst_status_bank.sv
module dbgst_status_bank #(
  parameter int unsigned N = dbgst_pkg::EVT_COUNT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  output logic [N-1:0] bits_q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic en;
    logic nxt;

    // R1, R2, R3: a new event wins over a clear in the same cycle
    always_comb begin
      en  = evt[i] | clr[i];
      nxt = evt[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bits_q[i] <= 1'b0;
      end else if (en) begin
        bits_q[i] <= nxt;
      end
    end
  end

endmodule

// File: rtl/dbgst_imprecise.sv
module dbgst_imprecise #(
  parameter int unsigned N = dbgst_pkg::EVT_COUNT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         dbg_en,
  input  logic         ext_mode_sel,
  input  logic [N-1:0] sw_own,
  input  logic         clr,
  output logic         flag_q
);

  logic [N-1:0] eligible;
  logic         set;
  logic         en;
  logic         nxt;

  always_comb begin
    // R6, R7: in external mode only software-owned resources count
    eligible = ext_mode_sel ? sw_own : {N{1'b1}};
    set      = (|(evt & eligible)) & ~dbg_en;
    en       = set | clr;
    nxt      = set;  // R8: set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (en) begin
      flag_q <= nxt;
    end
  end

endmodule

// File: rtl/dbgst_irq_gate.sv
module dbgst_irq_gate #(
  parameter int unsigned N = dbgst_pkg::EVT_COUNT
) (
  input  logic [N-1:0] bits_q,
  input  logic         dbg_en,
  input  logic         int_mode_en,
  input  logic         aux_en,
  output logic         irq,
  output logic         use_crit
);

  always_comb begin
    // R4, R5: pending bits are delivered once both enables are true
    irq      = (|bits_q) & dbg_en & int_mode_en;
    // R9
    use_crit = ~aux_en;
  end

endmodule

// File: rtl/dbg_status_ctrl.sv
module dbg_status_ctrl #(
  parameter int unsigned NUM_EVT = dbgst_pkg::EVT_COUNT,
  localparam int unsigned WD_W   = NUM_EVT + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic               dbg_en,
  input  logic               int_mode_en,
  input  logic               ext_mode_sel,
  input  logic [NUM_EVT-1:0] sw_own,
  input  logic               aux_en,
  input  logic               wr_en,
  input  logic [WD_W-1:0]    wr_data,
  output logic [NUM_EVT-1:0] status,
  output logic               imprecise,
  output logic               irq,
  output logic               use_crit_pair
);

  logic [NUM_EVT-1:0] clr_bits;
  logic               clr_imp;

  always_comb begin
    clr_bits = wr_data[NUM_EVT-1:0] & {NUM_EVT{wr_en}};
    clr_imp  = wr_data[NUM_EVT] & wr_en;
  end

  dbgst_status_bank #(.N(NUM_EVT)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt_pulse),
    .clr    (clr_bits),
    .bits_q (status)
  );

  dbgst_imprecise #(.N(NUM_EVT)) u_imp (
    .clk          (clk),
    .rst_n        (rst_n),
    .evt          (evt_pulse),
    .dbg_en       (dbg_en),
    .ext_mode_sel (ext_mode_sel),
    .sw_own       (sw_own),
    .clr          (clr_imp),
    .flag_q       (imprecise)
  );

  dbgst_irq_gate #(.N(NUM_EVT)) u_gate (
    .bits_q      (status),
    .dbg_en      (dbg_en),
    .int_mode_en (int_mode_en),
    .aux_en      (aux_en),
    .irq         (irq),
    .use_crit    (use_crit_pair)
  );

endmodule

// File: rtl/dbg_status_ctrl_chk.sv
module dbg_status_ctrl_chk #(
  parameter int unsigned NUM_EVT = dbgst_pkg::EVT_COUNT
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] evt_pulse,
  input logic               dbg_en,
  input logic               int_mode_en,
  input logic               ext_mode_sel,
  input logic [NUM_EVT-1:0] sw_own,
  input logic               aux_en,
  input logic               wr_en,
  input logic [NUM_EVT:0]   wr_data,
  input logic [NUM_EVT-1:0] status,
  input logic               imprecise,
  input logic               irq,
  input logic               use_crit_pair
);

  logic [NUM_EVT-1:0] qual_evt;
  always_comb qual_evt = evt_pulse & ~({NUM_EVT{ext_mode_sel}} & ~sw_own);

  assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((status & $past(evt_pulse)) == $past(evt_pulse)));

  assert_w1c_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((status & $past(wr_data[NUM_EVT-1:0]) & ~$past(evt_pulse)) == '0));

  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (dbg_en && int_mode_en && (|status)));

  assert_late_delivery_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_en && int_mode_en && (|status)) |-> irq);

  assert_imp_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dbg_en && (|qual_evt)) |=> imprecise);

  assert_imp_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[NUM_EVT] && !(!dbg_en && (|qual_evt))) |=> !imprecise);

  assert_pair_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    use_crit_pair == !aux_en);

endmodule

bind dbg_status_ctrl dbg_status_ctrl_chk #(.NUM_EVT(NUM_EVT)) u_chk (.*);

// File: tb/dbg_status_ctrl_bench.sv
`timescale 1ns/1ps
module dbg_status_ctrl_bench;

  localparam int N = 12;

  typedef struct packed {
    logic [3:0]  req;
    logic [11:0] evt;
    logic        dbg;
    logic        im;
    logic        ext;
    logic [11:0] own;
    logic        wr;
    logic [12:0] wd;
    logic        aux;
    logic [11:0] est;
    logic        eimp;
    logic        eirq;
    logic        ecrit;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    // R1/R6: masked event sets bit 0 and the imprecise flag
    '{req:1, evt:12'h001, dbg:0, im:0, ext:0, own:12'h000, wr:0, wd:13'h0000, aux:1, est:12'h001, eimp:1, eirq:0, ecrit:0},
    // R4: debug enabled but internal mode off, no request
    '{req:4, evt:12'h000, dbg:1, im:0, ext:0, own:12'h000, wr:0, wd:13'h0000, aux:1, est:12'h001, eimp:1, eirq:0, ecrit:0},
    // R5: both enables true, pending bit delivered late
    '{req:5, evt:12'h000, dbg:1, im:1, ext:0, own:12'h000, wr:0, wd:13'h0000, aux:1, est:12'h001, eimp:1, eirq:1, ecrit:0},
    // R8: clear imprecise via bit 12
    '{req:8, evt:12'h000, dbg:1, im:1, ext:0, own:12'h000, wr:1, wd:13'h1000, aux:1, est:12'h001, eimp:0, eirq:1, ecrit:0},
    // R7: event while enabled, no imprecise
    '{req:7, evt:12'h002, dbg:1, im:1, ext:0, own:12'h000, wr:0, wd:13'h0000, aux:1, est:12'h003, eimp:0, eirq:1, ecrit:0},
    // R2: clear bit 0
    '{req:2, evt:12'h000, dbg:1, im:1, ext:0, own:12'h000, wr:1, wd:13'h0001, aux:1, est:12'h002, eimp:0, eirq:1, ecrit:0},
    // R2: write of zeros has no effect
    '{req:2, evt:12'h000, dbg:1, im:1, ext:0, own:12'h000, wr:1, wd:13'h0000, aux:1, est:12'h002, eimp:0, eirq:1, ecrit:0},
    // R3: event and clear on bit 1 together
    '{req:3, evt:12'h002, dbg:1, im:1, ext:0, own:12'h000, wr:1, wd:13'h0002, aux:1, est:12'h002, eimp:0, eirq:1, ecrit:0},
    // R4: clear last bit with debug disabled
    '{req:4, evt:12'h000, dbg:0, im:1, ext:0, own:12'h000, wr:1, wd:13'h0002, aux:1, est:12'h000, eimp:0, eirq:0, ecrit:0},
    // R7: external mode, resource not owned, flag stays clear
    '{req:7, evt:12'h100, dbg:0, im:1, ext:1, own:12'h000, wr:0, wd:13'h0000, aux:1, est:12'h100, eimp:0, eirq:0, ecrit:0},
    // R6: external mode, resource owned by software
    '{req:6, evt:12'h200, dbg:0, im:1, ext:1, own:12'h200, wr:0, wd:13'h0000, aux:1, est:12'h300, eimp:1, eirq:0, ecrit:0},
    // R8: flag clear and qualifying event together, flag stays
    '{req:8, evt:12'h400, dbg:0, im:1, ext:0, own:12'h000, wr:1, wd:13'h1000, aux:1, est:12'h700, eimp:1, eirq:0, ecrit:0},
    // R9: aux unit off, clear everything
    '{req:9, evt:12'h000, dbg:1, im:1, ext:0, own:12'h000, wr:1, wd:13'h1FFF, aux:0, est:12'h000, eimp:0, eirq:0, ecrit:1},
    // R1: critical return event while enabled
    '{req:1, evt:12'h800, dbg:1, im:1, ext:0, own:12'h000, wr:0, wd:13'h0000, aux:0, est:12'h800, eimp:0, eirq:1, ecrit:1}
  };

  logic        clk;
  logic        rst_n;
  logic [11:0] evt_pulse;
  logic        dbg_en, int_mode_en, ext_mode_sel, aux_en, wr_en;
  logic [11:0] sw_own;
  logic [12:0] wr_data;
  logic [11:0] status;
  logic        imprecise, irq, use_crit_pair;

  int total;
  int bad;
  bit done;

  dbg_status_ctrl u_dbg_status_ctrl (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .dbg_en(dbg_en),
    .int_mode_en(int_mode_en), .ext_mode_sel(ext_mode_sel), .sw_own(sw_own),
    .aux_en(aux_en), .wr_en(wr_en), .wr_data(wr_data), .status(status),
    .imprecise(imprecise), .irq(irq), .use_crit_pair(use_crit_pair)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    evt_pulse = '0; wr_en = 0; wr_data = '0; ext_mode_sel = 0; sw_own = '0;
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    rst_n = 0; dbg_en = 1; int_mode_en = 1; aux_en = 1;
    idle();
    repeat (2) @(posedge clk);
    #5;
    // R10: reset state
    check("R10", status, 12'h000, "status in reset");
    check("R10", {11'd0, imprecise}, 12'h0, "imprecise in reset");
    check("R10", {11'd0, irq}, 12'h0, "irq in reset");
    @(negedge clk) rst_n = 1;

    for (int k = 0; k < NV; k++) begin
      string rq;
      @(negedge clk);
      evt_pulse = VEC[k].evt; dbg_en = VEC[k].dbg; int_mode_en = VEC[k].im;
      ext_mode_sel = VEC[k].ext; sw_own = VEC[k].own; wr_en = VEC[k].wr;
      wr_data = VEC[k].wd; aux_en = VEC[k].aux;
      @(posedge clk);
      #5;
      rq = $sformatf("R%0d row%0d", VEC[k].req, k);
      check(rq, status, VEC[k].est, "status");
      check(rq, {11'd0, imprecise}, {11'd0, VEC[k].eimp}, "imprecise");
      check(rq, {11'd0, irq}, {11'd0, VEC[k].eirq}, "irq");
      check(rq, {11'd0, use_crit_pair}, {11'd0, VEC[k].ecrit}, "use_crit_pair");
    end

    // R1/R6/R4: all sources fire at once while masked
    @(negedge clk);
    idle(); aux_en = 1; dbg_en = 0; int_mode_en = 1; evt_pulse = 12'hFFF;
    @(negedge clk);
    evt_pulse = '0;
    check("R1", status, 12'hFFF, "all bits set while masked");
    check("R6", {11'd0, imprecise}, 12'h1, "imprecise after burst");
    check("R4", {11'd0, irq}, 12'h0, "irq held while masked");
    // R5: enables rise with no new event
    dbg_en = 1;
    #1;
    check("R5", {11'd0, irq}, 12'h1, "late delivery");
    // R4: internal mode drop removes request
    int_mode_en = 0;
    #1;
    check("R4", {11'd0, irq}, 12'h0, "internal mode off");

    // R10: asynchronous reset mid-run with bits pending
    int_mode_en = 1;
    @(negedge clk) rst_n = 0;
    #2;
    check("R10", status, 12'h000, "status after async reset");
    check("R10", {11'd0, imprecise}, 12'h0, "imprecise after async reset");
    check("R10", {11'd0, irq}, 12'h0, "irq after async reset");
    @(negedge clk) rst_n = 1;
    @(negedge clk);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule